// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers the event causes of a two-channel ping-pong transfer engine into one register-mapped interrupt unit. Each channel reports five causes: command done, receive overrun, transmit underrun, poll timeout and invalid control. A single-cycle pulse on any cause latches a sticky bit in a raw status word, where each channel owns its own eight-bit lane. Software reads the raw word, the enable mask, or the masked status (raw ANDed with the mask), and clears latched causes by writing ones into the raw word.

One interrupt line is raised whenever any enabled cause is pending. Only the causes that exist are stored. Every other bit of every register reads as zero. The read path is combinational on the address. Writes take effect at the rising clock edge on which `reg_wr` is high.

Top module: `irq_group_ctrl`

## Requirements
- R1: A pulse on `evt_i[c*5+k]` sets raw status bit `c*8+k` at the next rising edge. The cause index k is 0 for command done, 1 for receive overrun, 2 for transmit underrun, 3 for poll timeout and 4 for invalid control.
- R2: A raw status bit, once set, stays set while no clearing write reaches it, even after its event input returns low.
- R3: A write to offset 0x08 clears each raw bit whose `reg_wdata` bit is 1 and leaves every other raw bit unchanged.
- R4: When an event and a clearing write reach the same raw bit in the same cycle, the bit is set after the edge.
- R5: Writing 0xFF001F1F to offset 0x08 clears all raw status bits.
- R6: Offset 0x10 holds the enable mask. It is written with `reg_wdata` and read back, stores only the defined cause bits (0x00001F1F), and writing zero disables every source.
- R7: Offset 0x0C reads raw status ANDed with the mask. Writes to it have no effect on raw status or the mask.
- R8: `irq` is registered: one edge after any change, it equals the OR of all masked status bits. A masked status of zero gives `irq` low.
- R9: Bits outside the defined cause positions read as zero in all three registers, and unmapped offsets read as zero.
- R10: After reset, raw status, mask, masked status and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Event pulses, bit c*5+k is cause k of channel c |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, high while an enabled cause is pending |

## Verification
A raw bit is due one rising edge after its event pulse or clearing write. Register reads are valid in the same cycle the address is presented. `irq` follows one edge after the raw or mask change it reflects, so it lags an event pulse by two edges. The bench drives every stimulus just after a falling edge and samples read data and `irq` after the following falling edge. By then each result has passed all of its registers, and no check lands on an edge.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

   // Cause index within a channel lane; the index is the bit offset in the lane.
   typedef enum int {
      CAUSE_DONE     = 0,
      CAUSE_RX_OVR   = 1,
      CAUSE_TX_UND   = 2,
      CAUSE_POLL_TO  = 3,
      CAUSE_BAD_CTRL = 4
   } cause_e;

   localparam int CAUSES_PER_CH = 5;

   // Bit position of compressed cause index i in the status word.
   function automatic int cause_bit_pos(int i, int ncause, int stride);
      return (i / ncause) * stride + (i % ncause);
   endfunction

   // Word with a one at every defined cause position.
   function automatic logic [63:0] defined_bits(int nch, int ncause, int stride);
      logic [63:0] m;
      m = '0;
      for (int c = 0; c < nch; c++) begin
         for (int k = 0; k < ncause; k++) begin
            m[c*stride + k] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/irq_cause_lane.sv
module irq_cause_lane #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] status
);

   // Sticky bits: a clear drops a bit, an event in the same cycle sets it again.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
      end else begin
         status <= (status & ~clr) | evt;
      end
   end

endmodule

// File: rtl/irq_mask_store.sv
module irq_mask_store #(
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
      end else if (wr_en) begin
         mask <= wr_data;
      end
   end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int RAW_OFS  = 'h08,
   parameter int MSKD_OFS = 'h0C,
   parameter int MASK_OFS = 'h10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] raw_word,
   input  logic [DATA_W-1:0] mask_word,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_OFS);
   localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(MSKD_OFS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

   always_comb begin
      if (addr == A_RAW) begin
         rdata = raw_word;
      end else if (addr == A_MSKD) begin
         rdata = raw_word & mask_word;
      end else if (addr == A_MASK) begin
         rdata = mask_word;
      end else begin
         rdata = '0;
      end
   end

endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
   parameter int NUM_CH         = 2,
   parameter int CAUSE_N        = irq_grp_pkg::CAUSES_PER_CH,
   parameter int LANE_STRIDE    = 8,
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 32,
   parameter int RAW_OFS        = 'h08,
   parameter int MSKD_OFS       = 'h0C,
   parameter int MASK_OFS       = 'h10,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH*CAUSE_N-1:0] evt_i,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_wr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   output logic                      irq
);

   localparam int FLAT_W = NUM_CH * CAUSE_N;
   localparam logic [DATA_W-1:0] DEF_BITS =
      DATA_W'(irq_grp_pkg::defined_bits(NUM_CH, CAUSE_N, LANE_STRIDE));
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_OFS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

   // Elaboration-time checks on the configuration.
   if (CAUSE_N > LANE_STRIDE) begin : g_bad_stride
      $error("irq_group_ctrl: CAUSE_N exceeds LANE_STRIDE");
   end
   if (NUM_CH * LANE_STRIDE > DATA_W) begin : g_bad_width
      $error("irq_group_ctrl: lanes do not fit in DATA_W");
   end
   if (DATA_W > 64) begin : g_bad_data
      $error("irq_group_ctrl: DATA_W above 64 not supported");
   end

   logic              raw_wr;
   logic              mask_wr;
   logic [FLAT_W-1:0] wdata_flat;
   logic [FLAT_W-1:0] raw_flat;
   logic [FLAT_W-1:0] mask_flat;
   logic [FLAT_W-1:0] clr_flat;
   logic [DATA_W-1:0] raw_word;
   logic [DATA_W-1:0] mask_word;
   logic              any_pending;
   logic              unused_wdata;

   assign raw_wr  = reg_wr && (reg_addr == A_RAW);
   assign mask_wr = reg_wr && (reg_addr == A_MASK);

   // Gather write data from lane positions into compressed cause order.
   for (genvar i = 0; i < FLAT_W; i++) begin : g_gather
      localparam int POS = irq_grp_pkg::cause_bit_pos(i, CAUSE_N, LANE_STRIDE);
      assign wdata_flat[i] = reg_wdata[POS];
   end
   assign unused_wdata = ^(reg_wdata & ~DEF_BITS);

   assign clr_flat = raw_wr ? wdata_flat : '0;

   // One sticky status lane per channel.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      irq_cause_lane #(
         .WIDTH (CAUSE_N)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt_i[c*CAUSE_N +: CAUSE_N]),
         .clr    (clr_flat[c*CAUSE_N +: CAUSE_N]),
         .status (raw_flat[c*CAUSE_N +: CAUSE_N])
      );
   end

   irq_mask_store #(
      .WIDTH (FLAT_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mask_wr),
      .wr_data (wdata_flat),
      .mask    (mask_flat)
   );

   // Scatter compressed state back to lane positions; gaps read as zero.
   always_comb begin
      raw_word  = '0;
      mask_word = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         raw_word[c*LANE_STRIDE +: CAUSE_N]  = raw_flat[c*CAUSE_N +: CAUSE_N];
         mask_word[c*LANE_STRIDE +: CAUSE_N] = mask_flat[c*CAUSE_N +: CAUSE_N];
      end
   end

   irq_read_mux #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RAW_OFS  (RAW_OFS),
      .MSKD_OFS (MSKD_OFS),
      .MASK_OFS (MASK_OFS)
   ) u_rmux (
      .addr      (reg_addr),
      .raw_word  (raw_word),
      .mask_word (mask_word),
      .rdata     (reg_rdata)
   );

   assign any_pending = |(raw_flat & mask_flat);

   if (IRQ_REGISTERED) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq <= 1'b0;
         end else begin
            irq <= any_pending;
         end
      end
   end else begin : g_irq_comb
      assign irq = any_pending;
   end

endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk #(
   parameter int NUM_CH         = 2,
   parameter int CAUSE_N        = 5,
   parameter int LANE_STRIDE    = 8,
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 32,
   parameter int RAW_OFS        = 'h08,
   parameter int MSKD_OFS       = 'h0C,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_CH*CAUSE_N-1:0] evt_i,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic                      reg_wr,
   input logic [DATA_W-1:0]         reg_wdata,
   input logic [DATA_W-1:0]         reg_rdata,
   input logic                      irq
);

   localparam int FLAT_W = NUM_CH * CAUSE_N;
   localparam logic [DATA_W-1:0] DEF_BITS =
      DATA_W'(irq_grp_pkg::defined_bits(NUM_CH, CAUSE_N, LANE_STRIDE));

   logic [FLAT_W-1:0] rd_flat;
   logic [FLAT_W-1:0] wd_flat;
   logic              raw_hit;
   logic              mskd_hit;

   for (genvar i = 0; i < FLAT_W; i++) begin : g_map
      localparam int POS = irq_grp_pkg::cause_bit_pos(i, CAUSE_N, LANE_STRIDE);
      assign rd_flat[i] = reg_rdata[POS];
      assign wd_flat[i] = reg_wdata[POS];
   end

   assign raw_hit  = (reg_addr == ADDR_W'(RAW_OFS));
   assign mskd_hit = (reg_addr == ADDR_W'(MSKD_OFS));

   // R1 / R4: every pulsed cause is visible in raw status after the edge.
   a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_hit && |evt_i) |=> (!raw_hit || ((rd_flat & $past(evt_i)) == $past(evt_i))));

   // R2: with no raw write, no set raw bit drops.
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_hit && !reg_wr) |=> (!raw_hit || ((rd_flat & $past(rd_flat)) == $past(rd_flat))));

   // R3: a written one without a coincident event clears the bit.
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_hit && reg_wr) |=> (!raw_hit || ((rd_flat & $past(wd_flat & ~evt_i)) == '0)));

   // R9: undefined bit positions always read as zero.
   a_r9_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rdata & ~DEF_BITS) == '0));

   // R7: masked status never shows more than raw status could hold.
   a_r7_masked_sub: assert property (@(posedge clk) disable iff (!rst_n)
      mskd_hit |-> ((reg_rdata & ~DEF_BITS) == '0));

   // R8: a masked read of zero held over two cycles leaves irq low.
   if (IRQ_REGISTERED) begin : g_irq_chk
      a_r8_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
         (mskd_hit && reg_rdata == '0 && !reg_wr && evt_i == '0)
            |=> (!(mskd_hit && reg_rdata == '0) || !irq));
   end

endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(
   .NUM_CH         (NUM_CH),
   .CAUSE_N        (CAUSE_N),
   .LANE_STRIDE    (LANE_STRIDE),
   .ADDR_W         (ADDR_W),
   .DATA_W         (DATA_W),
   .RAW_OFS        (RAW_OFS),
   .MSKD_OFS       (MSKD_OFS),
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq)
);

// File: tb/irq_group_ctrl_tb.sv
module irq_group_ctrl_tb;

   localparam int NEV = 10;
   localparam logic [7:0] A_RAW  = 8'h08;
   localparam logic [7:0] A_MSKD = 8'h0C;
   localparam logic [7:0] A_MASK = 8'h10;
   localparam logic [31:0] DEF = 32'h0000_1F1F;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NEV-1:0] evt_i = '0;
   logic [7:0]     reg_addr = '0;
   logic           reg_wr = 1'b0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           irq;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_raw  = '0;
   logic [31:0] exp_mask = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_group_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   function automatic logic [31:0] pos_of(int i);
      return 32'(1) << ((i / 5) * 8 + (i % 5));
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(logic [NEV-1:0] ev);
      @(negedge clk);
      evt_i = ev;
      @(negedge clk);
      evt_i = '0;
      for (int i = 0; i < NEV; i++) if (ev[i]) exp_raw |= pos_of(i);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == A_RAW)  exp_raw  &= ~d;
      if (a == A_MASK) exp_mask  = d & DEF;
   endtask

   task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic chk_irq(string req);
      @(negedge clk);
      check(req, {31'b0, irq}, {31'b0, |(exp_raw & exp_mask)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      #1;
      check("R10 irq in reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      rd("R10 raw", A_RAW, 32'h0);
      rd("R10 masked", A_MSKD, 32'h0);
      rd("R10 mask", A_MASK, 32'h0);
      chk_irq("R10 irq");

      // Sweep every cause of every channel
      for (int i = 0; i < NEV; i++) begin
         pulse(NEV'(1) << i);
         rd("R1 raw position", A_RAW, pos_of(i));
         rd("R7 masked with mask off", A_MSKD, 32'h0);
         chk_irq("R8 irq masked off");
         wr(A_MASK, pos_of(i));
         rd("R6 mask readback", A_MASK, pos_of(i));
         rd("R7 masked enabled", A_MSKD, pos_of(i));
         chk_irq("R8 irq raised");
         repeat (3) @(negedge clk);
         rd("R2 sticky", A_RAW, pos_of(i));
         wr(A_RAW, ~pos_of(i));
         rd("R3 other bits kept", A_RAW, pos_of(i));
         wr(A_RAW, pos_of(i));
         rd("R3 cleared", A_RAW, 32'h0);
         chk_irq("R8 irq dropped");
         wr(A_MASK, 32'h0);
      end

      // R5: clear-all with every cause pending
      pulse('1);
      rd("R1 all causes", A_RAW, DEF);
      wr(A_MASK, 32'hFFFF_FFFF);
      rd("R6 mask only defined bits", A_MASK, DEF);
      rd("R7 masked all", A_MSKD, DEF);
      chk_irq("R8 irq all");
      wr(A_MSKD, 32'hFFFF_FFFF);
      rd("R7 masked write ignored raw", A_RAW, DEF);
      rd("R7 masked write ignored mask", A_MASK, DEF);
      wr(A_RAW, 32'hFF00_1F1F);
      rd("R5 clear all", A_RAW, 32'h0);
      chk_irq("R5 irq after clear all");

      // R4: event and clear on the same bit in the same cycle
      pulse(10'b00_0000_1001);
      @(negedge clk);
      reg_addr = A_RAW; reg_wdata = 32'h0000_0009; reg_wr = 1'b1;
      evt_i = 10'b00_0000_1000;
      @(negedge clk);
      reg_wr = 1'b0; evt_i = '0;
      exp_raw = 32'h0000_0008;
      rd("R4 event wins", A_RAW, 32'h0000_0008);

      // R6: mask of zero disables everything
      wr(A_MASK, 32'h0);
      rd("R6 masked zero", A_MSKD, 32'h0);
      chk_irq("R6 irq disabled");

      // R9: unmapped offsets and lane gaps
      rd("R9 offset 0", 8'h00, 32'h0);
      rd("R9 offset 0x14", 8'h14, 32'h0);
      pulse(10'b10_0000_0000);
      rd("R9 lane 1 cause 4", A_RAW, 32'h0000_1008);
      wr(A_RAW, 32'hFF00_1F1F);
      rd("R5 final clear", A_RAW, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule